// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder

This block sits beside an 8-bit controller whose low address byte and data share one 8-bit bus. When the address strobe falls, the block takes the byte then on the bus and holds it as the low half of a 12-bit external address. The upper four address bits come from the lines of a second controller port. The same port lines also select the device that takes part in each read or write cycle: display RAM, buffer RAM, the CRT controllers or the UART.

A mode input sets how the port is read. In memory selection mode, the four low port lines are address bits and one line picks the RAM bank. In device selection mode, the port's lowest line tells the CRT controllers whether the bus byte is a command or data. The other upper address lines are then ignored.

Separately, the program store strobe drives the ROM output enable, and one port line steers UART transmit data to the modem port or to the printer port. All strobes and selects are active low.

Top module: `mux_bus_decoder`

## Requirements
- R1: The low address byte `addr[7:0]` takes the value of `bus_in` at the first rising clock edge at which `ale` is sampled low after being sampled high. It then holds that value, whatever the bus does, until the next such edge. Reset clears it to 0.
- R2: With `mem_mode` = 1, `addr[11:8]` equals `port2[3:0]`, so `port2[0]` is A8 and `port2[3]` is A11. With `mem_mode` = 0, `addr[11:8]` is 0, whatever `port2[3:1]` holds.
- R3: At most one bit of `dev_cs_n` is low at any time. All of them are high when neither `rd_n` nor `wr_n` is low. The index map is 0 = display RAM, 1 = buffer RAM, 2 = CRT controllers, 3 = UART.
- R4: When `port2[5]` = 1 during a read or write cycle, the UART is selected in either mode.
- R5: In memory selection mode with `port2[5]` = 0, `port2[4]` = 1 selects display RAM and `port2[4]` = 0 selects buffer RAM.
- R6: In device selection mode with `port2[5]` = 0, the CRT controllers are selected. `crt_cmd` equals `port2[0]` in device selection mode (1 = command, 0 = data) and is 0 in memory selection mode.
- R7: `rd_n` and `wr_n` are passed on only to the selected device's `dev_rd_n` and `dev_wr_n` bits. Every other bit stays high.
- R8: While `ale` is high, every bit of `dev_cs_n`, `dev_rd_n` and `dev_wr_n` is high.
- R9: `rom_oe_n` equals `psen_n`. No other input affects it.
- R10: `to_printer` equals `port2[7]` (1 = printer port, 0 = modem port).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe from the controller; the byte is captured on its fall |
| psen_n | input | 1 | Program store enable from the controller |
| rd_n | input | 1 | Read strobe from the controller |
| wr_n | input | 1 | Write strobe from the controller |
| bus_in | input | 8 | Shared address/data bus |
| port2 | input | 8 | Second controller port (address high bits, bank, UART enable, route) |
| mem_mode | input | 1 | 1 = memory selection mode, 0 = device selection mode |
| addr | output | 12 | External address |
| dev_cs_n | output | 4 | Device selects, active low |
| dev_rd_n | output | 4 | Per-device read strobes, active low |
| dev_wr_n | output | 4 | Per-device write strobes, active low |
| crt_cmd | output | 1 | 1 = CRT controller command byte, 0 = data byte |
| rom_oe_n | output | 1 | Program ROM output enable, active low |
| to_printer | output | 1 | UART transmit route, 1 = printer port |

## Verification
The assertions check the following on every cycle:
- No two devices are selected at once.
- No select or strobe is active while the address strobe is high.
- No strobe reaches a device that is not selected.
- The latched byte is captured on the strobe's fall and then held.
- `crt_cmd` is never raised in memory selection mode.

Which device a given mix of port lines and mode picks can only be shown by the bench's scenarios. The same holds for the exact high address bits, the command and data polarity, the route select, and the fact that the ROM enable does not depend on the read strobe. The bench compares these against its own model over directed and random bus cycles.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int DATA_W = 8;
  localparam int HI_W   = 4;
  localparam int ADDR_W = DATA_W + HI_W;
  localparam int N_DEV  = 4;

  // device index map
  localparam int DEV_DSP  = 0;
  localparam int DEV_BUF  = 1;
  localparam int DEV_CRT  = 2;
  localparam int DEV_UART = 3;

  // port line roles
  localparam int P_CMD   = 0;
  localparam int P_BANK  = 4;
  localparam int P_UART  = 5;
  localparam int P_ROUTE = 7;

  // one-hot (active high) device choice for a cycle
  function automatic logic [N_DEV-1:0] pick_device(
    input logic        active,
    input logic        mem_mode,
    input logic [7:0]  p2
  );
    logic [N_DEV-1:0] s;
    s = '0;
    if (active) begin
      if (p2[P_UART])      s[DEV_UART] = 1'b1;
      else if (!mem_mode)  s[DEV_CRT]  = 1'b1;
      else if (p2[P_BANK]) s[DEV_DSP]  = 1'b1;
      else                 s[DEV_BUF]  = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [HI_W-1:0] high_bits(
    input logic       mem_mode,
    input logic [7:0] p2
  );
    return mem_mode ? p2[HI_W-1:0] : '0;
  endfunction
endpackage

// File: rtl/mbd_addr_latch.sv
module mbd_addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ale,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] lo_byte,
  output logic         fire
);
  logic ale_q;

  assign fire = ale_q & ~ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q   <= 1'b0;
      lo_byte <= '0;
    end else begin
      ale_q <= ale;
      if (fire) lo_byte <= bus_in;
    end
  end
endmodule

// File: rtl/mbd_sel_decode.sv
module mbd_sel_decode
  import mbd_pkg::*;
(
  input  logic             ale,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             mem_mode,
  input  logic [7:0]       port2,
  output logic [N_DEV-1:0] sel,
  output logic [HI_W-1:0]  hi_addr,
  output logic             crt_cmd,
  output logic             to_printer,
  output logic             cycle_live
);
  assign cycle_live = (~rd_n | ~wr_n) & ~ale;
  assign sel        = pick_device(cycle_live, mem_mode, port2);
  assign hi_addr    = high_bits(mem_mode, port2);
  assign crt_cmd    = ~mem_mode & port2[P_CMD];
  assign to_printer = port2[P_ROUTE];
endmodule

// File: rtl/mbd_strobe_gate.sv
module mbd_strobe_gate #(
  parameter int N = 4
) (
  input  logic [N-1:0] sel,
  input  logic         rd_n,
  input  logic         wr_n,
  output logic [N-1:0] cs_n,
  output logic [N-1:0] rd_o_n,
  output logic [N-1:0] wr_o_n
);
  for (genvar i = 0; i < N; i++) begin : g_dev
    assign cs_n[i]   = ~sel[i];
    assign rd_o_n[i] = ~(sel[i] & ~rd_n);
    assign wr_o_n[i] = ~(sel[i] & ~wr_n);
  end
endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder
  import mbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              psen_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [7:0]        port2,
  input  logic              mem_mode,
  output logic [ADDR_W-1:0] addr,
  output logic [N_DEV-1:0]  dev_cs_n,
  output logic [N_DEV-1:0]  dev_rd_n,
  output logic [N_DEV-1:0]  dev_wr_n,
  output logic              crt_cmd,
  output logic              rom_oe_n,
  output logic              to_printer
);
  logic [DATA_W-1:0] lo_byte;
  logic              latch_fire;
  logic [N_DEV-1:0]  dev_sel;
  logic [HI_W-1:0]   hi_addr;
  logic              cycle_live;

  mbd_addr_latch #(.W(DATA_W)) latch_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .bus_in(bus_in),
    .lo_byte(lo_byte), .fire(latch_fire)
  );

  mbd_sel_decode dec_i (
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .mem_mode(mem_mode),
    .port2(port2), .sel(dev_sel), .hi_addr(hi_addr),
    .crt_cmd(crt_cmd), .to_printer(to_printer), .cycle_live(cycle_live)
  );

  mbd_strobe_gate #(.N(N_DEV)) gate_i (
    .sel(dev_sel), .rd_n(rd_n), .wr_n(wr_n),
    .cs_n(dev_cs_n), .rd_o_n(dev_rd_n), .wr_o_n(dev_wr_n)
  );

  assign addr     = {hi_addr, lo_byte};
  assign rom_oe_n = psen_n;
endmodule

// File: rtl/mux_bus_decoder_chk.sv
module mux_bus_decoder_chk
  import mbd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              mem_mode,
  input logic [DATA_W-1:0] bus_in,
  input logic              latch_fire,
  input logic [ADDR_W-1:0] addr,
  input logic [N_DEV-1:0]  dev_cs_n,
  input logic [N_DEV-1:0]  dev_rd_n,
  input logic [N_DEV-1:0]  dev_wr_n,
  input logic              crt_cmd
);
  p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dev_cs_n));

  p_idle_no_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> (&dev_cs_n));

  p_quiet_during_ale_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ((&dev_cs_n) && (&dev_rd_n) && (&dev_wr_n)));

  p_rd_only_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dev_rd_n) & dev_cs_n) == '0);

  p_wr_only_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dev_wr_n) & dev_cs_n) == '0);

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fire |=> (addr[DATA_W-1:0] == $past(bus_in)));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_fire |=> $stable(addr[DATA_W-1:0]));

  p_cmd_device_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crt_cmd |-> !mem_mode);

  p_hi_zero_device_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_mode |-> (addr[ADDR_W-1:DATA_W] == '0));
endmodule

bind mux_bus_decoder mux_bus_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .mem_mode(mem_mode), .bus_in(bus_in), .latch_fire(latch_fire),
  .addr(addr), .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n),
  .dev_wr_n(dev_wr_n), .crt_cmd(crt_cmd)
);

// File: tb/mux_bus_decoder_tb_top.sv
`timescale 1ns/1ps
module mux_bus_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic        psen_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [7:0]  bus_in = '0;
  logic [7:0]  port2 = '0;
  logic        mem_mode = 1'b0;
  logic [11:0] addr;
  logic [3:0]  dev_cs_n, dev_rd_n, dev_wr_n;
  logic        crt_cmd, rom_oe_n, to_printer;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mux_bus_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .bus_in(bus_in), .port2(port2), .mem_mode(mem_mode),
    .addr(addr), .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n),
    .dev_wr_n(dev_wr_n), .crt_cmd(crt_cmd), .rom_oe_n(rom_oe_n),
    .to_printer(to_printer)
  );

  typedef struct {
    logic [11:0] addr;
    logic [3:0]  cs_n, rd_n, wr_n;
    logic        cmd, oe_n, prt;
  } exp_t;

  exp_t sb_q[$];
  event vec_ready;
  logic [7:0] model_lo = '0;

  // bench model, written from the requirements
  function automatic exp_t predict(logic a, logic ps, logic r, logic w,
                                   logic [7:0] p2, logic mm, logic [7:0] lo);
    exp_t e;
    logic go;
    logic [3:0] pick;
    go   = (!r || !w) && !a;
    pick = 4'b0000;
    if (go) begin
      case ({p2[5], mm, p2[4]})
        3'b100, 3'b101, 3'b110, 3'b111: pick = 4'b1000; // R4 UART
        3'b000, 3'b001:                 pick = 4'b0100; // R6 CRT
        3'b011:                         pick = 4'b0001; // R5 display
        default:                        pick = 4'b0010; // R5 buffer
      endcase
    end
    e.addr = {mm ? p2[3:0] : 4'h0, lo};
    e.cs_n = ~pick;
    e.rd_n = r ? 4'hF : ~pick;
    e.wr_n = w ? 4'hF : ~pick;
    e.cmd  = mm ? 1'b0 : p2[0];
    e.oe_n = ps;
    e.prt  = p2[7];
    return e;
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: pops the scoreboard when a vector has settled
  initial begin
    forever begin
      @(vec_ready);
      if (sb_q.size() == 0) begin
        cmp("R1 scoreboard", 32'd0, 32'd1);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        cmp("R1/R2 addr", {20'd0, addr}, {20'd0, e.addr});
        cmp("R3/R4/R5/R6/R8 cs", {28'd0, dev_cs_n}, {28'd0, e.cs_n});
        cmp("R7 rd", {28'd0, dev_rd_n}, {28'd0, e.rd_n});
        cmp("R7 wr", {28'd0, dev_wr_n}, {28'd0, e.wr_n});
        cmp("R6 crt_cmd", {31'd0, crt_cmd}, {31'd0, e.cmd});
        cmp("R9 rom_oe_n", {31'd0, rom_oe_n}, {31'd0, e.oe_n});
        cmp("R10 to_printer", {31'd0, to_printer}, {31'd0, e.prt});
      end
    end
  end

  task automatic push_and_sample();
    sb_q.push_back(predict(ale, psen_n, rd_n, wr_n, port2, mem_mode, model_lo));
    #1;
    ->vec_ready;
    #0.1;
  endtask

  // driver: one full bus cycle, address phase then data phase
  task automatic bus_cycle(logic [7:0] lo, logic [7:0] data, logic [7:0] p2,
                           logic mm, logic r, logic w, logic ps);
    @(negedge clk);
    ale = 1'b1; bus_in = lo; port2 = p2; mem_mode = mm;
    rd_n = r; wr_n = w; psen_n = ps;
    push_and_sample();                 // R8: strobes held off, old address
    @(negedge clk);
    ale = 1'b0;                        // capture at next rising edge
    @(negedge clk);
    model_lo = lo;
    bus_in = data;                     // R1: bus turns to data, address held
    push_and_sample();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    push_and_sample();
    rst_n = 1'b1;
    @(negedge clk);
    // R5 display RAM read, address bits from port
    bus_cycle(8'h3C, 8'hA5, 8'b0001_1010, 1'b1, 1'b0, 1'b1, 1'b1);
    // R5 buffer RAM write
    bus_cycle(8'hF0, 8'h11, 8'b0000_0101, 1'b1, 1'b1, 1'b0, 1'b1);
    // R6 CRT command write, R2 high bits ignored in device mode
    bus_cycle(8'h81, 8'h22, 8'b0000_1111, 1'b0, 1'b1, 1'b0, 1'b1);
    // R6 CRT data read
    bus_cycle(8'h07, 8'h33, 8'b0000_1110, 1'b0, 1'b0, 1'b1, 1'b1);
    // R4 UART in memory mode, R10 printer route
    bus_cycle(8'h55, 8'h44, 8'b1011_0011, 1'b1, 1'b0, 1'b1, 1'b1);
    // R4 UART in device mode, modem route
    bus_cycle(8'hAA, 8'h66, 8'b0010_0001, 1'b0, 1'b1, 1'b0, 1'b1);
    // R3 no strobe: nothing selected; R9 fetch with psen only
    bus_cycle(8'h12, 8'h77, 8'b0001_1111, 1'b1, 1'b1, 1'b1, 1'b0);
    // R9 psen high while read active
    bus_cycle(8'h34, 8'h88, 8'b0000_0000, 1'b1, 1'b0, 1'b1, 1'b1);
    // R1 hold: bus wiggles with ale low, address must not move
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bus_in = 8'(k * 37 + 9);
      push_and_sample();
    end
    // random cycles
    for (int n = 0; n < 300; n++) begin
      logic [2:0] st;
      st = 3'($urandom_range(0, 7));
      bus_cycle(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
                st[0], st[1], st[2]);
    end
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule